// File: doc/BRIEF.md
# Interval Tick Timer

The interval tick timer gives a system a steady periodic time base. A fixed prescaler divides the system clock by 16. Each prescaled tick advances a 20-bit interval counter, which returns to zero once it has spent the programmed number of ticks in one period. Each completed period raises a status flag and increments a 12-bit period tally. Software reads both counters through either of two views. The acknowledging view clears the flag and the tally. The image view returns the same data and changes nothing.

A level interrupt follows the status flag while interrupts are enabled. Software can also leave the interrupt disabled and poll the counters as a free-running clock. When the timer is switched off, the interval counter finishes its current period before it halts at zero. The bus port is a plain single-cycle port. A read strobe with an address returns the registered word one clock later.

Top module: `interval_tick_timer`

## Requirements
- R1: After a synchronous reset, the control word, the interval counter, the period tally and the status flag are all zero, and `tick_irq` is low.
- R2: The control word at offset 0x0 holds the period value in bits [19:0], the run enable in bit 24 and the interrupt enable in bit 25. It reads back with every other bit zero.
- R3: While running, the interval counter advances by one every 16 clocks. The first step comes 16 clocks after the enabling write. After the step that finds it at or above the period value, it returns to 0, so one period lasts (period value + 1) ticks.
- R4: Each return to zero sets the status flag, which is bit 0 of offset 0x4.
- R5: Offset 0x8 returns the tally in bits [31:20] and the interval counter in bits [19:0]. Reading it clears the status flag and the tally after the read.
- R6: Offset 0xC returns the same layout as 0x8 and changes no state.
- R7: If a return to zero coincides with a read of 0x8, the tally becomes 1 and the status flag stays set.
- R8: The tally stops at 4095 and does not wrap.
- R9: When the run enable is cleared, the interval counter keeps stepping until it returns to zero, and then it holds at zero.
- R10: `tick_irq` is high exactly when both the status flag and the interrupt enable are set. With the interrupt enable clear, the counters keep running and the interrupt stays low.
- R11: Writes to 0x4, 0x8 and 0xC change no state.
- R12: Read data appears the clock after the read strobe and is zero in every other cycle. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick_irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an acknowledging read that lands on the same clock edge as a period wrap. The bench sets a period value of zero, so a wrap happens on every sixteenth edge from the enabling write. It then counts the idle cycles so that the read strobe is sampled on the wrap edge itself. The run-on after disable is found the same way. The enable is dropped at a known point within a period, and the counter is sampled before the period ends, after it ends, and later at a time when a running counter would read nonzero.

// File: rtl/itt_pkg.sv
package itt_pkg;
  // register offsets (byte addresses)
  localparam logic [3:0] OFF_CTRL  = 4'h0;
  localparam logic [3:0] OFF_STAT  = 4'h4;
  localparam logic [3:0] OFF_VALUE = 4'h8;
  localparam logic [3:0] OFF_IMAGE = 4'hC;

  // control word bit positions decoded by software
  localparam int RUN_BIT = 24;
  localparam int IEN_BIT = 25;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_VALUE,
    SEL_IMAGE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [3:0] a);
    case (a)
      OFF_CTRL:  decode = SEL_CTRL;
      OFF_STAT:  decode = SEL_STAT;
      OFF_VALUE: decode = SEL_VALUE;
      OFF_IMAGE: decode = SEL_IMAGE;
      default:   decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/itt_prescaler.sv
module itt_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/itt_counter.sv
module itt_counter #(
  parameter int VAL_W = 20,
  parameter int OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             enable,
  input  logic [VAL_W-1:0] period,
  input  logic             ack,
  output logic [VAL_W-1:0] cur,
  output logic [OVF_W-1:0] ovf,
  output logic             status,
  output logic             active
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic [VAL_W-1:0] cur_q;
  logic [OVF_W-1:0] ovf_q;
  logic             status_q;
  logic             wrap;

  assign wrap   = tick && (cur_q >= period);
  assign active = enable || (cur_q != '0);
  assign cur    = cur_q;
  assign ovf    = ovf_q;
  assign status = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else if (tick) begin
      cur_q <= wrap ? '0 : cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (wrap) status_q <= 1'b1;
      else if (ack) status_q <= 1'b0;

      if (ack) ovf_q <= wrap ? OVF_W'(1) : '0;
      else if (wrap && ovf_q != OVF_MAX) ovf_q <= ovf_q + 1'b1;
    end
  end

  // R3
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cur_q));
  // R4
  wrap_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> status_q);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !wrap) |=> (!status_q && ovf_q == '0));
  // R7
  ack_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && wrap) |=> (status_q && ovf_q == OVF_W'(1)));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q == OVF_MAX && !ack) |=> ovf_q == OVF_MAX);
  // R9
  stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && cur_q == '0) |=> cur_q == '0);
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int PRESCALE = 16,
  parameter int VAL_W    = 20,
  parameter int OVF_W    = 12,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  import itt_pkg::*;

  localparam int OVF_LSB = VAL_W;

  logic [VAL_W-1:0]  period_q;
  logic              run_q;
  logic              ien_q;
  logic [VAL_W-1:0]  cur;
  logic [OVF_W-1:0]  ovf;
  logic              status;
  logic              active;
  logic              tick;
  logic              ack;
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] image_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign sel = decode(bus_addr);
  assign ack = bus_rd && (sel == SEL_VALUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (bus_wr && sel == SEL_CTRL) begin
      period_q <= bus_wdata[VAL_W-1:0];
      run_q    <= bus_wdata[RUN_BIT];
      ien_q    <= bus_wdata[IEN_BIT];
    end
  end

  itt_prescaler #(.DIV(PRESCALE)) i_prescaler (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  itt_counter #(.VAL_W(VAL_W), .OVF_W(OVF_W)) i_counter (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .enable (run_q),
    .period (period_q),
    .ack    (ack),
    .cur    (cur),
    .ovf    (ovf),
    .status (status),
    .active (active)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[VAL_W-1:0] = period_q;
    ctrl_word[RUN_BIT]   = run_q;
    ctrl_word[IEN_BIT]   = ien_q;
    image_word = '0;
    image_word[VAL_W-1:0]         = cur;
    image_word[OVF_LSB +: OVF_W]  = ovf;
    case (sel)
      SEL_CTRL:  rd_mux = ctrl_word;
      SEL_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, status};
      SEL_VALUE: rd_mux = image_word;
      SEL_IMAGE: rd_mux = image_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) rdata_q <= '0;
    else rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign tick_irq  = status && ien_q;

  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!status || !ien_q) |-> !tick_irq);
endmodule

// File: tb/test_interval_tick_timer.sv
module test_interval_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_tick_timer i_interval_tick_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  adr;
    logic [31:0] dat;
    logic [15:0] gap;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // timeline: period 3, run on, interrupt off; state sampled at j clocks after enabling write
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 32'h0100_0003, 16'd0,  32'h0,         4'd2},  // R2 program
    '{1'b1, 4'hC, 32'h0,         16'd20, 32'h0000_0001, 4'd3},  // R3 j=20
    '{1'b1, 4'h0, 32'h0,         16'd0,  32'h0100_0003, 4'd2},  // R2 readback
    '{1'b1, 4'hC, 32'h0,         16'd41, 32'h0000_0003, 4'd3},  // R3 j=63
    '{1'b1, 4'h4, 32'h0,         16'd0,  32'h0000_0001, 4'd4},  // R4 wrap at 64
    '{1'b1, 4'hC, 32'h0,         16'd0,  32'h0010_0000, 4'd6},  // R6 no clear
    '{1'b1, 4'h8, 32'h0,         16'd0,  32'h0010_0000, 4'd5},  // R5 ack
    '{1'b1, 4'h4, 32'h0,         16'd0,  32'h0,         4'd5},  // R5 status cleared
    '{1'b1, 4'hC, 32'h0,         16'd0,  32'h0,         4'd5},  // R5 tally cleared
    '{1'b0, 4'h4, 32'hFFFF_FFFF, 16'd0,  32'h0,         4'd11}, // R11
    '{1'b1, 4'h4, 32'h0,         16'd0,  32'h0,         4'd11}, // R11
    '{1'b1, 4'h8, 32'h0,         16'd57, 32'h0010_0000, 4'd3},  // R3 j=128
    '{1'b0, 4'hC, 32'hFFFF_FFFF, 16'd0,  32'h0,         4'd11}, // R11
    '{1'b1, 4'hC, 32'h0,         16'd0,  32'h0,         4'd11}, // R11
    '{1'b0, 4'h8, 32'hFFFF_FFFF, 16'd0,  32'h0,         4'd11}, // R11
    '{1'b1, 4'h0, 32'h0,         16'd0,  32'h0100_0003, 4'd11}, // R11 ctrl intact
    '{1'b1, 4'h6, 32'h0,         16'd0,  32'h0,         4'd12}  // R12 unmapped
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(4'h0, d); check(d, 32'h0, 1, "ctrl after reset");
    rd(4'hC, d); check(d, 32'h0, 1, "image after reset");
    rd(4'h4, d); check(d, 32'h0, 1, "status after reset");
    check({31'h0, tick_irq}, 32'h0, 1, "irq after reset");

    do_reset();
    for (int i = 0; i < NV; i++) begin
      idle(int'(VEC[i].gap));
      if (VEC[i].rd) begin
        rd(VEC[i].adr, d);
        check(d, VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
      end else begin
        wr(VEC[i].adr, VEC[i].dat);
      end
    end

    // R12 data returns to zero the cycle after a read
    idle(1);
    check(bus_rdata, 32'h0, 12, "rdata idle");
    // R10 status set with interrupt disabled: no irq (j=194)
    idle(58);
    rd(4'h4, d); check(d, 32'h1, 10, "status with irq off");
    check({31'h0, tick_irq}, 32'h0, 10, "irq held low");
    wr(4'h0, 32'h0300_0003);
    check({31'h0, tick_irq}, 32'h1, 10, "irq after enable");
    rd(4'h8, d);
    check({31'h0, tick_irq}, 32'h0, 10, "irq after ack");

    // R7 acknowledge on the wrap edge, period value 0
    do_reset();
    wr(4'h0, 32'h0300_0000);
    idle(15);
    rd(4'h8, d); check(d, 32'h0, 7, "value before coinciding wrap");
    rd(4'h4, d); check(d, 32'h1, 7, "status survives ack");
    rd(4'hC, d); check(d, 32'h0010_0000, 7, "tally is one");
    check({31'h0, tick_irq}, 32'h1, 7, "irq survives ack");

    // R8 saturation after more than 4095 periods
    idle(4200 * 16);
    rd(4'hC, d); check(d, 32'hFFF0_0000, 8, "tally saturated");

    // R9 disable mid-period, period 3
    do_reset();
    wr(4'h0, 32'h0100_0003);
    idle(19);
    wr(4'h0, 32'h0000_0003);
    idle(29);
    rd(4'hC, d); check(d, 32'h0000_0003, 9, "still counting after disable");
    idle(49);
    rd(4'hC, d); check(d, 32'h0010_0000, 9, "stopped at zero");
    idle(122);
    rd(4'hC, d); check(d, 32'h0010_0000, 9, "remains stopped");

    finish_run();
  end
endmodule